// File: doc/BRIEF.md
# Auto-acknowledging interrupt event controller

This block gathers a set of level-sensitive interrupt lines and hands them out to several CPUs through one event register that every CPU shares. Each line carries a mask bit, a software request bit and a CPU routing bitmask. A line requests service when its hardware input or its software bit is high. It is offered to a CPU when it is unmasked and the routing bitmask includes that CPU. Each CPU has its own interrupt output, which stays high while at least one line is offered to it.

A CPU services an interrupt by reading the event register over a simple register bus, and it names itself on the CPU-ID sideband. The read returns the lowest-numbered line offered to that CPU and masks that line in the same cycle. This one read therefore identifies the interrupt and acknowledges it. Software ends the interrupt later by clearing the mask. A line whose input is still high is then delivered again. When nothing is offered, the read returns zero and changes no state.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset every line is masked, every software bit is 0, every routing register holds 1 (CPU 0 only), every bit of `cpu_irq` is low, and `rsp_valid` is low.
- R2: A read at offset 0x0004 returns the number of implemented lines in bits [15:0], with the upper bits 0.
- R3: Writing ones to 0x4200 + 4*(n>>5) masks lines, and writing ones to 0x4300 + 4*(n>>5) unmasks them. Line n is bit n[4:0] of the word, and zero bits leave lines unchanged. A read at either address returns the mask bits of that word, where 1 means masked.
- R4: Writing ones to 0x4000 + 4*(n>>5) sets software bits, and writing ones to 0x4100 + 4*(n>>5) clears them. Both use the same word and bit layout as R3, and a read at either address returns the software bits. The request of a line is its input ORed with its software bit.
- R5: The routing register of line n is at 0x3000 + 4*n. Its bits [N_CPUS-1:0] are a bitmask in which bit c selects CPU c. It reads back as written, and a line is offered only to the CPUs whose bits are set.
- R6: A read at the event register (offset 0x1000) returns the word {8'h00, 8'h01, 16-bit line number}: bits [31:24] are 0, bits [23:16] hold the type code 1 for a hardware interrupt, and bits [15:0] hold the line number. When several lines are offered to the reading CPU, the lowest line number is returned.
- R7: An event read that returns a line sets that line's mask bit, so the bit reads back as 1 from the next cycle. The read leaves the software bits and the other lines unchanged.
- R8: An event read made while nothing is offered to the reading CPU returns 0 and changes no mask bit.
- R9: `cpu_irq[c]` is high exactly when some unmasked line with an active request has bit c set in its routing register.
- R10: If a line's request is still active when the line is unmasked again, the line is offered again and returned by the next event read.
- R11: Every read gives `rsp_valid` high for exactly the next cycle, with the data in `rsp_rdata`. A write gives no response, and a read at an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Level-sensitive interrupt inputs |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Identity of the accessing CPU |
| req_addr | input | 16 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | 32 | Read data |
| cpu_irq | output | N_CPUS | Per-CPU interrupt request |

## Verification
The assertions assume one bus access per cycle, a `req_cpu` value below N_CPUS, and word-aligned addresses. The auto-mask and empty-read properties treat a line's mask bit as changed only by the access made in the previous cycle. The stimulus keeps to these assumptions. It drives every access and every change of an interrupt input half a cycle away from the sampling edge, and it issues accesses one at a time through a task. It uses only the CPU numbers 0 to 3 and only aligned offsets, including a single aligned offset at which no register is mapped.

// File: rtl/irq_ev_pkg.sv
package irq_ev_pkg;

    localparam logic [15:0] OFS_INFO     = 16'h0004;
    localparam logic [15:0] OFS_EVENT    = 16'h1000;
    localparam logic [15:0] OFS_TARGET   = 16'h3000;
    localparam logic [15:0] OFS_SW_SET   = 16'h4000;
    localparam logic [15:0] OFS_SW_CLR   = 16'h4100;
    localparam logic [15:0] OFS_MASK_SET = 16'h4200;
    localparam logic [15:0] OFS_MASK_CLR = 16'h4300;

    localparam logic [7:0] EVT_DIE     = 8'h00;
    localparam logic [7:0] EVT_KIND_HW = 8'h01;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_INFO,
        RG_EVENT,
        RG_TARGET,
        RG_SW_SET,
        RG_SW_CLR,
        RG_MASK_SET,
        RG_MASK_CLR
    } region_e;

    function automatic logic [31:0] pack_event(input logic [15:0] num);
        return {EVT_DIE, EVT_KIND_HW, num};
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_ev_pkg::*;
#(
    parameter int N_LINES = 64,
    localparam int N_WORDS = (N_LINES + 31) / 32,
    localparam int LIDX_W  = $clog2(N_LINES),
    localparam int WIDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic [15:0]       addr,
    output region_e           region,
    output logic [LIDX_W-1:0] line,
    output logic [WIDX_W-1:0] word
);

    localparam logic [15:0] TGT_SPAN  = 16'(4 * N_LINES);
    localparam logic [15:0] WORD_SPAN = 16'(4 * N_WORDS);

    logic [15:0] off_tgt, off_sws, off_swc, off_mks, off_mkc;

    always_comb begin
        off_tgt = addr - OFS_TARGET;
        off_sws = addr - OFS_SW_SET;
        off_swc = addr - OFS_SW_CLR;
        off_mks = addr - OFS_MASK_SET;
        off_mkc = addr - OFS_MASK_CLR;
        region  = RG_NONE;
        line    = '0;
        word    = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == OFS_INFO) begin
                region = RG_INFO;
            end else if (addr == OFS_EVENT) begin
                region = RG_EVENT;
            end else if (addr >= OFS_TARGET && off_tgt < TGT_SPAN) begin
                region = RG_TARGET;
                line   = LIDX_W'(off_tgt >> 2);
            end else if (addr >= OFS_SW_SET && off_sws < WORD_SPAN) begin
                region = RG_SW_SET;
                word   = WIDX_W'(off_sws >> 2);
            end else if (addr >= OFS_SW_CLR && off_swc < WORD_SPAN) begin
                region = RG_SW_CLR;
                word   = WIDX_W'(off_swc >> 2);
            end else if (addr >= OFS_MASK_SET && off_mks < WORD_SPAN) begin
                region = RG_MASK_SET;
                word   = WIDX_W'(off_mks >> 2);
            end else if (addr >= OFS_MASK_CLR && off_mkc < WORD_SPAN) begin
                region = RG_MASK_CLR;
                word   = WIDX_W'(off_mkc >> 2);
            end
        end
    end

endmodule

// File: rtl/irq_cpu_route.sv
module irq_cpu_route #(
    parameter int N_LINES = 64,
    parameter int N_CPUS  = 4
) (
    input  logic [N_LINES-1:0]             active,
    input  logic [N_LINES-1:0][N_CPUS-1:0] target,
    output logic [N_CPUS-1:0][N_LINES-1:0] pend,
    output logic [N_CPUS-1:0]              any
);

    for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
        for (genvar i = 0; i < N_LINES; i++) begin : g_line
            assign pend[c][i] = active[i] & target[i][c];
        end
        assign any[c] = |pend[c];
    end

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int W = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
    import irq_ev_pkg::*;
#(
    parameter int N_LINES = 64,
    parameter int N_CPUS  = 4,
    localparam int CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic [15:0]        req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [N_CPUS-1:0]  cpu_irq
);

    localparam int N_WORDS = (N_LINES + 31) / 32;
    localparam int PAD     = N_WORDS * 32;
    localparam int LIDX_W  = $clog2(N_LINES);
    localparam int WIDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    typedef struct packed {
        logic [N_LINES-1:0]             mask;
        logic [N_LINES-1:0]             sw;
        logic [N_LINES-1:0][N_CPUS-1:0] target;
        logic                           rvalid;
        logic [31:0]                    rdata;
    } state_t;

    state_t s_q, s_d;

    region_e           dec_region;
    logic [LIDX_W-1:0] dec_line;
    logic [WIDX_W-1:0] dec_word;

    logic [N_LINES-1:0]             mask_cur;
    logic [N_LINES-1:0]             active;
    logic [N_CPUS-1:0][N_LINES-1:0] pend;
    logic [N_LINES-1:0]             pend_sel;
    logic                           sel_found;
    logic [LIDX_W-1:0]              sel_idx;

    assign mask_cur = s_q.mask;
    assign active   = (irq_in | s_q.sw) & ~s_q.mask;
    assign pend_sel = pend[req_cpu];

    irq_addr_decode #(.N_LINES(N_LINES)) u_dec (
        .addr   (req_addr),
        .region (dec_region),
        .line   (dec_line),
        .word   (dec_word)
    );

    irq_cpu_route #(.N_LINES(N_LINES), .N_CPUS(N_CPUS)) u_route (
        .active (active),
        .target (s_q.target),
        .pend   (pend),
        .any    (cpu_irq)
    );

    irq_first_set #(.W(N_LINES)) u_pick (
        .vec   (pend_sel),
        .found (sel_found),
        .idx   (sel_idx)
    );

    logic               rd_en, wr_en;
    logic [PAD-1:0]     wvec, sw_pad, mask_pad;
    logic [N_LINES-1:0] sw_set, sw_clr, mk_set, mk_clr, automask;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        s_d.rdata  = '0;
        rd_en      = req_valid && !req_write;
        wr_en      = req_valid && req_write;
        sw_pad     = PAD'(s_q.sw);
        mask_pad   = PAD'(s_q.mask);
        wvec       = '0;
        wvec[32*int'(dec_word) +: 32] = req_wdata;
        sw_set     = '0;
        sw_clr     = '0;
        mk_set     = '0;
        mk_clr     = '0;
        automask   = '0;

        if (rd_en) begin
            s_d.rvalid = 1'b1;
            case (dec_region)
                RG_INFO:   s_d.rdata = {16'h0000, 16'(N_LINES)};
                RG_EVENT: begin
                    if (sel_found) begin
                        s_d.rdata         = pack_event(16'(sel_idx));
                        automask[sel_idx] = 1'b1;
                    end
                end
                RG_TARGET: s_d.rdata = 32'(s_q.target[dec_line]);
                RG_SW_SET, RG_SW_CLR:
                    s_d.rdata = sw_pad[32*int'(dec_word) +: 32];
                RG_MASK_SET, RG_MASK_CLR:
                    s_d.rdata = mask_pad[32*int'(dec_word) +: 32];
                default:   s_d.rdata = '0;
            endcase
        end

        if (wr_en) begin
            case (dec_region)
                RG_TARGET:   s_d.target[dec_line] = req_wdata[N_CPUS-1:0];
                RG_SW_SET:   sw_set = wvec[N_LINES-1:0];
                RG_SW_CLR:   sw_clr = wvec[N_LINES-1:0];
                RG_MASK_SET: mk_set = wvec[N_LINES-1:0];
                RG_MASK_CLR: mk_clr = wvec[N_LINES-1:0];
                default: ;
            endcase
        end

        s_d.sw   = (s_q.sw | sw_set) & ~sw_clr;
        s_d.mask = ((s_q.mask | mk_set) & ~mk_clr) | automask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mask   <= '1;
            s_q.sw     <= '0;
            s_q.rvalid <= 1'b0;
            s_q.rdata  <= '0;
            for (int i = 0; i < N_LINES; i++) begin
                s_q.target[i] <= N_CPUS'(1);
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rvalid;
    assign rsp_rdata = s_q.rdata;

endmodule

// File: rtl/irq_event_ctrl_chk.sv
module irq_event_ctrl_chk
    import irq_ev_pkg::*;
#(
    parameter int N_LINES = 64,
    parameter int N_CPUS  = 4,
    localparam int CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1,
    localparam int LIDX_W = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [CPU_W-1:0]   req_cpu,
    input logic [15:0]        req_addr,
    input logic               rsp_valid,
    input logic [31:0]        rsp_rdata,
    input logic [N_CPUS-1:0]  cpu_irq,
    input logic [N_LINES-1:0] mask_q
);

    logic is_rd, is_evt, evt_q;

    assign is_rd  = req_valid && !req_write;
    assign is_evt = is_rd && (req_addr == OFS_EVENT);

    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= is_evt;
    end

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rsp_valid);  // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !rsp_valid);  // R11
    AST_EVENT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && rsp_rdata != 32'h0) |-> (rsp_rdata[31:16] == 16'h0001));  // R6
    AST_READ_MASKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && rsp_rdata != 32'h0) |-> mask_q[rsp_rdata[LIDX_W-1:0]]);  // R7
    AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_evt && !cpu_irq[req_cpu]) |=> (rsp_rdata == 32'h0 && $stable(mask_q)));  // R8
    AST_IRQ_YIELDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_evt && cpu_irq[req_cpu]) |=> (rsp_rdata != 32'h0));  // R9

endmodule

bind irq_event_ctrl irq_event_ctrl_chk #(.N_LINES(N_LINES), .N_CPUS(N_CPUS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_cpu   (req_cpu),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .cpu_irq   (cpu_irq),
    .mask_q    (mask_cur)
);

// File: tb/sim_irq_event_ctrl.sv
`timescale 1ns/1ps
module sim_irq_event_ctrl;

    localparam int NL = 64;
    localparam int NC = 4;

    localparam logic [15:0] A_INFO = 16'h0004;
    localparam logic [15:0] A_EVT  = 16'h1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_cpu = '0;
    logic [15:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NC-1:0] cpu_irq;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    irq_event_ctrl #(.N_LINES(NL), .N_CPUS(NC)) u0 (
        .clk, .rst_n, .irq_in, .req_valid, .req_write, .req_cpu,
        .req_addr, .req_wdata, .rsp_valid, .rsp_rdata, .cpu_irq
    );

    function automatic logic [15:0] a_tgt(input int n);  return 16'h3000 + 16'(4 * n); endfunction
    function automatic logic [15:0] a_sws(input int w);  return 16'h4000 + 16'(4 * w); endfunction
    function automatic logic [15:0] a_swc(input int w);  return 16'h4100 + 16'(4 * w); endfunction
    function automatic logic [15:0] a_mks(input int w);  return 16'h4200 + 16'(4 * w); endfunction
    function automatic logic [15:0] a_mkc(input int w);  return 16'h4300 + 16'(4 * w); endfunction
    function automatic logic [31:0] ev(input int n);     return {8'h00, 8'h01, 16'(n)}; endfunction

    // Monitor: pops one expected word per response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R11 unexpected response: got %h expected none", rsp_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    miscompares++;
                    $display("FAIL %s: got %h expected %h", t, rsp_rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [15:0] a, input int c, input logic [31:0] e, input string t);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_cpu = 2'(c);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_cpu = 2'd0;
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic chk_irq(input logic [NC-1:0] e, input string t);
        @(negedge clk);
        vectors++;
        if (cpu_irq !== e) begin
            miscompares++;
            $display("FAIL %s: got %b expected %b", t, cpu_irq, e);
        end
    endtask

    task automatic set_line(input int n, input logic v);
        @(negedge clk);
        irq_in[n] = v;
    endtask

    initial begin
        #(200000 * 10);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_irq(4'b0000, "R1 irq low after reset");
        rd(A_INFO, 0, 32'd64, "R2 line count");
        rd(a_mks(0), 0, 32'hFFFF_FFFF, "R1 mask word0 all set");
        rd(a_mkc(1), 0, 32'hFFFF_FFFF, "R1 mask word1 all set");
        rd(a_sws(0), 0, 32'h0, "R1 software bits clear");
        rd(a_tgt(5), 0, 32'h1, "R1 routing defaults to cpu0");
        rd(A_EVT, 0, 32'h0, "R8 empty read");
        rd(a_mks(0), 0, 32'hFFFF_FFFF, "R8 empty read leaves masks");

        // R3 masked lines stay silent, then unmask
        set_line(5, 1'b1);
        set_line(40, 1'b1);
        chk_irq(4'b0000, "R3 masked lines silent");
        wr(a_mkc(0), 32'h1 << 5);
        wr(a_mkc(1), 32'h1 << 8);
        chk_irq(4'b0001, "R9 cpu0 requested");
        rd(a_mks(0), 0, 32'hFFFF_FFDF, "R3 clear of bit 5");
        rd(A_EVT, 1, 32'h0, "R5 cpu1 not routed");
        rd(A_EVT, 0, ev(5), "R6 lowest line first");
        rd(a_mks(0), 0, 32'hFFFF_FFFF, "R7 read masked line 5");
        rd(A_EVT, 0, ev(40), "R6 next line");
        rd(A_EVT, 0, 32'h0, "R8 nothing left");
        chk_irq(4'b0000, "R7 irq drops after reads");
        rd(a_mks(1), 0, 32'hFFFF_FFFF, "R7 read masked line 40");

        // R10 level input redelivered after unmask
        wr(a_mkc(0), 32'h1 << 5);
        chk_irq(4'b0001, "R10 line 5 offered again");
        rd(A_EVT, 0, ev(5), "R10 redelivery");
        set_line(5, 1'b0);

        // R5 routing
        wr(a_tgt(40), 32'h4);
        rd(a_tgt(40), 0, 32'h4, "R5 routing readback");
        wr(a_mkc(1), 32'h1 << 8);
        chk_irq(4'b0100, "R5 line 40 to cpu2 only");
        rd(A_EVT, 0, 32'h0, "R5 cpu0 sees nothing");
        rd(A_EVT, 2, ev(40), "R5 cpu2 gets line 40");
        set_line(40, 1'b0);

        // R3 mask set
        set_line(10, 1'b1);
        wr(a_mkc(0), 32'h1 << 10);
        chk_irq(4'b0001, "R9 line 10 offered");
        wr(a_mks(0), 32'h1 << 10);
        chk_irq(4'b0000, "R3 mask set silences line 10");
        rd(A_EVT, 0, 32'h0, "R3 masked line not returned");
        set_line(10, 1'b0);

        // R4 software requests
        wr(a_sws(0), 32'h0000_0208);
        rd(a_sws(0), 0, 32'h0000_0208, "R4 software bits set");
        rd(a_swc(0), 0, 32'h0000_0208, "R4 readable at clear address");
        wr(a_mkc(0), 32'h0000_0208);
        chk_irq(4'b0001, "R4 software request raises irq");
        rd(A_EVT, 0, ev(3), "R4 software line 3");
        rd(a_sws(0), 0, 32'h0000_0208, "R7 software bits untouched by read");
        wr(a_swc(0), 32'h1 << 9);
        rd(a_sws(0), 0, 32'h0000_0008, "R4 software clear");
        rd(A_EVT, 0, 32'h0, "R4 cleared request gone");
        wr(a_swc(0), 32'h1 << 3);

        // R6 priority across words, hardware and software mixed
        set_line(0, 1'b1);
        set_line(63, 1'b1);
        wr(a_sws(0), 32'h8000_0000);
        wr(a_mkc(0), 32'h8000_0001);
        wr(a_mkc(1), 32'h8000_0000);
        rd(A_EVT, 0, ev(0), "R6 line 0 first");
        rd(A_EVT, 0, ev(31), "R6 line 31 second");
        rd(A_EVT, 0, ev(63), "R6 line 63 last");
        rd(A_EVT, 0, 32'h0, "R8 all serviced");

        rd(16'h0008, 0, 32'h0, "R11 unmapped read");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            miscompares++;
            $display("FAIL R11 missing responses: got %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule